// File: doc/BRIEF.md
# Issue-Group Tag Allocator with Register Checkpoints

This block hands out group numbers to sets of instructions as they enter an out-of-order execution window. When a group is issued, the block stores two precomputed 64-bit register vectors in the group's slot. The first is a snapshot of the physical-register valid bits taken at issue time. The second lists the physical registers that may be handed back to the free list once the group completes. The numbers come from a small ring of slots. Issue is allowed only while a number is free, so the availability flag is the single gate that upstream logic needs to check before sending a new group.

Groups leave the ring in two ways. A retire strobe releases the oldest group: its to-free vector is presented for the free list and its number becomes reusable. A recover strobe names a live group N. The block returns N's saved valid vector so the live valid bits can be overwritten. It then broadcasts a kill tag for N and for every younger group, one tag per cycle, so that reservation stations and execution units drop those instructions. The tail of the ring is moved back to N, so N is the next number granted.

Top module: `issue_group_ckpt`

## Requirements
- R1: After synchronous reset the ring is empty, `issue_avail` is 1, and `kill_valid`, `restore_valid` and `freed_valid` are 0.
- R2: In a cycle where `issue_req` is 1 and `issue_avail` is 1 and `recover_req` is 0, `issue_grant` is 1 in that same cycle. `issue_tag` carries the granted number. Numbers are granted in ascending order modulo GROUPS (default 8), starting from 0 after reset.
- R3: At most GROUPS groups are outstanding. When all are outstanding, `issue_avail` is 0 and requests get no grant.
- R4: A retire with at least one group outstanding releases the oldest group. In the next cycle `freed_valid` is 1 and `freed_vec` equals that group's to-free vector. A retire with no group outstanding has no effect.
- R5: An accepted recover of group N sets `restore_valid` to 1 in the next cycle, with `restore_vec` equal to the valid vector stored when N was issued.
- R6: From the cycle after an accepted recover of N, `kill_valid` is 1 and `kill_tag` steps through N, N+1 and so on (modulo GROUPS), one per cycle, through the youngest outstanding group. After that, `kill_valid` drops and the next number granted is N.
- R7: No grant is given, and `issue_avail` is 0, while a kill sequence is running. No grant is given in a cycle where `recover_req` is 1.
- R8: When `retire_req` and `recover_req` are both 1, the retire is ignored.
- R9: A recover naming a number that is not outstanding, or one arriving while a kill sequence is running, is ignored.
- R10: An issue and a retire in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_req | input | 1 | Request to open a new group |
| issue_valid_vec | input | 64 | Valid-bit snapshot to store for the group |
| issue_free_vec | input | 64 | Registers to free if the group retires |
| issue_grant | output | 1 | Request accepted this cycle |
| issue_tag | output | 3 | Number given to the group |
| issue_avail | output | 1 | A number is available and no kill sequence is running |
| retire_req | input | 1 | Retire the oldest group |
| recover_req | input | 1 | Recover to the named group |
| recover_tag | input | 3 | Group number to recover |
| kill_valid | output | 1 | Kill broadcast is valid |
| kill_tag | output | 3 | Group number being killed |
| restore_valid | output | 1 | Restore vector is valid |
| restore_vec | output | 64 | Saved valid bits to write back |
| freed_valid | output | 1 | Freed vector is valid |
| freed_vec | output | 64 | Registers returned to the free list |

## Verification
`issue_grant`, `issue_tag` and `issue_avail` are combinational from the inputs and the current state. The bench therefore samples them 1 ns after it drives the inputs, before the next rising edge. `restore_vec`, `freed_vec` and the first kill tag are registered and appear in the cycle after the accepting edge; later kill tags follow one per edge. The bench reads all registered outputs 1 ns after each edge. A behavioural queue model advances once per edge and is compared on every cycle against both groups of outputs.

// File: rtl/gtag_pkg.sv
package gtag_pkg;

    localparam int GTAG_GROUPS_DEF = 8;
    localparam int GTAG_PREGS_DEF  = 64;

    // Actions accepted in one cycle; issue and retire may coexist.
    typedef struct packed {
        logic issue;
        logic retire;
        logic recover;
    } gtag_act_t;

    // Offset of a slot index from the ring head, modulo the ring size.
    function automatic int unsigned ring_offset(input int unsigned idx,
                                                input int unsigned head,
                                                input int unsigned size);
        return (idx + size - (head % size)) % size;
    endfunction

endpackage

// File: rtl/gtag_ring.sv
module gtag_ring
    import gtag_pkg::*;
#(
    parameter int GROUPS = GTAG_GROUPS_DEF,
    localparam int IW = $clog2(GROUPS),
    localparam int PW = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue_req,
    input  logic          retire_req,
    input  logic          recover_req,
    input  logic [IW-1:0] recover_tag,
    input  logic          walk_busy,
    output logic          grant,
    output logic [IW-1:0] tail_idx,
    output logic [IW-1:0] head_idx,
    output logic          avail,
    output gtag_act_t     act,
    output logic [PW-1:0] rec_target,
    output logic [PW-1:0] tail_ext
);

    localparam logic [PW-1:0] CAP = PW'(GROUPS);

    logic [PW-1:0] head_q, tail_q, count;
    logic [IW-1:0] off;
    logic          full, empty, live;

    assign count = tail_q - head_q;
    assign full  = (count == CAP);
    assign empty = (count == '0);

    assign off        = recover_tag - head_q[IW-1:0];
    assign live       = ({1'b0, off} < count);
    assign rec_target = head_q + PW'(off);

    assign act.recover = recover_req && !walk_busy && live;
    assign act.retire  = retire_req && !recover_req && !empty;
    assign act.issue   = issue_req && !full && !walk_busy && !recover_req;

    assign grant    = act.issue;
    assign avail    = !full && !walk_busy;
    assign tail_idx = tail_q[IW-1:0];
    assign head_idx = head_q[IW-1:0];
    assign tail_ext = tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (act.recover)
                tail_q <= rec_target;
            else if (act.issue)
                tail_q <= tail_q + 1'b1;
            if (act.retire)
                head_q <= head_q + 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CAP); // R3

    AST_ISSUE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (grant && !act.retire) |=> (count == $past(count) + 1'b1)); // R2

    AST_EMPTY_RETIRE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (empty && retire_req) |=> (head_q == $past(head_q))); // R4

    AST_RECOVER_WINS: assert property (@(posedge clk) disable iff (rst)
        (recover_req && retire_req) |=> (head_q == $past(head_q))); // R8

endmodule

// File: rtl/gtag_walker.sv
module gtag_walker
    import gtag_pkg::*;
#(
    parameter int GROUPS = GTAG_GROUPS_DEF,
    localparam int IW = $clog2(GROUPS),
    localparam int PW = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [PW-1:0] first_ptr,
    input  logic [PW-1:0] stop_ptr,
    output logic          busy,
    output logic [IW-1:0] kill_tag
);

    logic [PW-1:0] ptr_q, stop_q;

    assign busy     = (ptr_q != stop_q);
    assign kill_tag = ptr_q[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            stop_q <= '0;
        end else if (start) begin
            ptr_q  <= first_ptr;
            stop_q <= stop_ptr;
        end else if (busy) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    AST_KILL_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (!busy || kill_tag == IW'($past(kill_tag) + 1'b1))); // R6

endmodule

// File: rtl/gtag_store.sv
module gtag_store
    import gtag_pkg::*;
#(
    parameter int GROUPS = GTAG_GROUPS_DEF,
    parameter int PREGS  = GTAG_PREGS_DEF,
    localparam int IW = $clog2(GROUPS)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [PREGS-1:0] wr_valid,
    input  logic [PREGS-1:0] wr_free,
    input  logic [IW-1:0]    free_idx,
    output logic [PREGS-1:0] free_out,
    input  logic [IW-1:0]    snap_idx,
    output logic [PREGS-1:0] snap_out
);

    logic [PREGS-1:0] valid_mem [GROUPS];
    logic [PREGS-1:0] free_mem  [GROUPS];

    for (genvar g = 0; g < GROUPS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IW'(g)) begin
                valid_mem[g] <= wr_valid;
                free_mem[g]  <= wr_free;
            end
        end
    end

    assign free_out = free_mem[free_idx];
    assign snap_out = valid_mem[snap_idx];

endmodule

// File: rtl/issue_group_ckpt.sv
module issue_group_ckpt
    import gtag_pkg::*;
#(
    parameter int GROUPS = GTAG_GROUPS_DEF,
    parameter int PREGS  = GTAG_PREGS_DEF,
    localparam int IW = $clog2(GROUPS),
    localparam int PW = IW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_req,
    input  logic [PREGS-1:0] issue_valid_vec,
    input  logic [PREGS-1:0] issue_free_vec,
    output logic             issue_grant,
    output logic [IW-1:0]    issue_tag,
    output logic             issue_avail,
    input  logic             retire_req,
    input  logic             recover_req,
    input  logic [IW-1:0]    recover_tag,
    output logic             kill_valid,
    output logic [IW-1:0]    kill_tag,
    output logic             restore_valid,
    output logic [PREGS-1:0] restore_vec,
    output logic             freed_valid,
    output logic [PREGS-1:0] freed_vec
);

    gtag_act_t        act;
    logic             walk_busy;
    logic [IW-1:0]    head_idx;
    logic [PW-1:0]    rec_target, tail_ext;
    logic [PREGS-1:0] free_rd, snap_rd;

    gtag_ring #(.GROUPS(GROUPS)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .issue_req  (issue_req),
        .retire_req (retire_req),
        .recover_req(recover_req),
        .recover_tag(recover_tag),
        .walk_busy  (walk_busy),
        .grant      (issue_grant),
        .tail_idx   (issue_tag),
        .head_idx   (head_idx),
        .avail      (issue_avail),
        .act        (act),
        .rec_target (rec_target),
        .tail_ext   (tail_ext)
    );

    gtag_walker #(.GROUPS(GROUPS)) u_walk (
        .clk      (clk),
        .rst      (rst),
        .start    (act.recover),
        .first_ptr(rec_target),
        .stop_ptr (tail_ext),
        .busy     (walk_busy),
        .kill_tag (kill_tag)
    );

    gtag_store #(.GROUPS(GROUPS), .PREGS(PREGS)) u_store (
        .clk     (clk),
        .wr_en   (act.issue),
        .wr_idx  (issue_tag),
        .wr_valid(issue_valid_vec),
        .wr_free (issue_free_vec),
        .free_idx(head_idx),
        .free_out(free_rd),
        .snap_idx(recover_tag),
        .snap_out(snap_rd)
    );

    assign kill_valid = walk_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            restore_valid <= 1'b0;
            restore_vec   <= '0;
            freed_valid   <= 1'b0;
            freed_vec     <= '0;
        end else begin
            restore_valid <= act.recover;
            freed_valid   <= act.retire;
            if (act.recover) restore_vec <= snap_rd;
            if (act.retire)  freed_vec   <= free_rd;
        end
    end

    AST_RESTORE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        act.recover |=> (restore_valid && kill_valid && kill_tag == $past(recover_tag))); // R5

    AST_FREE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        act.retire |=> freed_valid); // R4

    AST_NO_GRANT_IN_KILL: assert property (@(posedge clk) disable iff (rst)
        kill_valid |-> !issue_grant); // R7

    AST_IDLE_RESET: assert property (@(posedge clk)
        $past(rst) |-> (!kill_valid && !restore_valid && !freed_valid)); // R1

endmodule

// File: tb/tb_issue_group_ckpt.sv
module tb_issue_group_ckpt;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_req = 1'b0;
    logic [63:0] issue_valid_vec = '0;
    logic [63:0] issue_free_vec = '0;
    logic        issue_grant;
    logic [2:0]  issue_tag;
    logic        issue_avail;
    logic        retire_req = 1'b0;
    logic        recover_req = 1'b0;
    logic [2:0]  recover_tag = '0;
    logic        kill_valid;
    logic [2:0]  kill_tag;
    logic        restore_valid;
    logic [63:0] restore_vec;
    logic        freed_valid;
    logic [63:0] freed_vec;

    always #2.5 clk = ~clk;

    issue_group_ckpt dut (.*);

    int    n_chk = 0;
    int    n_bad = 0;
    string ph = "R1";

    logic [63:0] m_v [int];
    logic [63:0] m_f [int];
    int hd = 0, tl = 0, kp = 0, ke = 0;

    task automatic chk(input logic ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", ph, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // One cycle: drive at negedge, check combinational outputs, advance model at edge,
    // check registered outputs 1 ns after the edge.
    task automatic cyc(input logic rq, input logic rt, input logic rc, input logic [2:0] rtg);
        logic [63:0] v, f;
        logic busy, full, g_e, rec_ok, ret_ok, e_rv, e_fv;
        logic [63:0] e_rvec, e_fvec;
        int off, tgt;
        v = {$urandom, $urandom};
        f = {$urandom, $urandom};
        issue_req = rq; retire_req = rt; recover_req = rc; recover_tag = rtg;
        issue_valid_vec = v; issue_free_vec = f;
        #1;
        busy = (kp < ke);
        full = ((tl - hd) == 8);
        g_e = rq && !full && !busy && !rc;
        chk(issue_grant == g_e, "grant", 64'(issue_grant), 64'(g_e));
        chk(issue_avail == (!full && !busy), "avail", 64'(issue_avail), 64'(!full && !busy));
        if (g_e) chk(issue_tag == 3'(tl % 8), "issue_tag", 64'(issue_tag), 64'(tl % 8));
        off = gtag_pkg::ring_offset(int'(rtg), hd, 8);
        rec_ok = rc && !busy && (off < (tl - hd));
        ret_ok = rt && !rc && (tl > hd);
        tgt = hd + off;
        e_rv = rec_ok; e_fv = ret_ok; e_rvec = '0; e_fvec = '0;
        if (rec_ok) begin
            e_rvec = m_v[tgt];
            kp = tgt; ke = tl; tl = tgt;
        end else if (busy) begin
            kp++;
        end
        if (g_e) begin
            m_v[tl] = v; m_f[tl] = f; tl++;
        end
        if (ret_ok) begin
            e_fvec = m_f[hd]; hd++;
        end
        @(posedge clk);
        #1;
        chk(restore_valid == e_rv, "restore_valid", 64'(restore_valid), 64'(e_rv));
        if (e_rv) chk(restore_vec == e_rvec, "restore_vec", restore_vec, e_rvec);
        chk(freed_valid == e_fv, "freed_valid", 64'(freed_valid), 64'(e_fv));
        if (e_fv) chk(freed_vec == e_fvec, "freed_vec", freed_vec, e_fvec);
        chk(kill_valid == (kp < ke), "kill_valid", 64'(kill_valid), 64'(kp < ke));
        if (kp < ke) chk(kill_tag == 3'(kp % 8), "kill_tag", 64'(kill_tag), 64'(kp % 8));
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        ph = "R1";
        chk(issue_avail == 1'b1, "avail after reset", 64'(issue_avail), 64'd1);
        chk(!kill_valid && !restore_valid && !freed_valid, "idle outputs",
            {61'd0, kill_valid, restore_valid, freed_valid}, 64'd0);
        // R4: retire on empty ring
        ph = "R4";
        cyc(0, 1, 0, 0);
        // R2: sequential grants
        ph = "R2";
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
        // R4: retire oldest two
        ph = "R4";
        cyc(0, 1, 0, 0);
        cyc(0, 1, 0, 0);
        // R10: issue and retire together
        ph = "R10";
        cyc(1, 1, 0, 0);
        cyc(1, 1, 0, 0);
        // R3: fill the ring and keep asking
        ph = "R3";
        for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0);
        // R9: recover of a dead number (ring full: every tag live), so first drain one
        ph = "R4";
        cyc(0, 1, 0, 0);
        ph = "R9";
        cyc(0, 0, 1, 3'(tl % 8));   // slot at tail is not outstanding
        // R5 and R6: recover a middle group, then watch the kill sequence
        ph = "R5";
        cyc(0, 0, 1, 3'((hd + 3) % 8));
        ph = "R7";
        cyc(1, 0, 0, 0);
        ph = "R9";
        cyc(0, 0, 1, 3'(hd % 8));   // arrives during kill sequence
        ph = "R6";
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0);
        // R8: retire and recover together
        ph = "R8";
        cyc(0, 1, 1, 3'((hd + 1) % 8));
        ph = "R6";
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0);
        ph = "R7";
        cyc(1, 0, 1, 3'((tl + 1) % 8));
        // Mixed traffic
        ph = "R6";
        for (int i = 0; i < 400; i++)
            cyc(($urandom % 3) != 0, ($urandom % 3) == 0, ($urandom % 16) == 0, 3'($urandom % 8));
        summary();
        $finish;
    end

endmodule